// File: doc/BRIEF.md
# Defect-Mapping Programmable Address Decoder

The block turns a small logical address into a one-hot select over a larger group of physical wires, most of which carry a random, fixed bootstrap code and some of which are missing or broken. After a configuration request, a sequencer sweeps every legal bootstrap code and records which wires answer alone. It then walks the wires in index order and gives each usable wire a programmed dual-rail mask that decides which address lines it waits on. Wires that are unusable, duplicated or left over as spares get a mask with every line enabled, so they can never conduct.

Each wire's select in operation is an AND over the address lines its mask enables. Lines that are not enabled are don't-cares. A logical address presents bit `b` on two lines: the true line `2b+1` carries the bit and the complement line `2b` carries its inverse. A mapped wire enables exactly one of the two lines per bit. A fully enabled mask would need a bit to be both 0 and 1, so such a wire stays dark. When a mapped wire later fails, it can be retired at run time: its mask is parked and its address moves onto the lowest-indexed spare.

Top module: `defect_map_decoder`

## Requirements
- R1: After reset, `wire_sel_o`, `sel_valid_o`, `good_o`, `cfg_done_o`, `err_dup_o` and `err_short_o` are all zero.
- R2: A configuration request sweeps every `CL`-bit code of weight `CW`. A wire is flagged in `good_o` when it is not marked defective, its code equals a swept code, and no other non-defective wire carries the same code. A wire whose code has a weight other than `CW` is never flagged.
- R3: When two or more non-defective wires carry the same legal code, `err_dup_o` is raised and none of those wires is flagged good or mapped.
- R4: Logical address k is mapped to the k-th good wire in ascending wire index. With `cfg_done_o` high, `run_i` high and `addr_valid_i` high, the register after the clock edge that samples address k shows exactly that wire's bit on `wire_sel_o`, and `sel_valid_o` is high.
- R5: A wire whose mask is parked (defective, absent, duplicated, spare or retired) is never selected, and `wire_sel_o` never has more than one bit set.
- R6: If fewer good wires than `2**AB` exist, `err_short_o` is raised with `cfg_done_o`. Addresses without a wire select nothing.
- R7: No wire is selected and `sel_valid_o` stays low one cycle after any edge where `run_i`, `addr_valid_i` or `cfg_done_o` is low, including while configuration is still running.
- R8: A retire request on a mapped wire parks it, clears its good flag and moves its address to the lowest-indexed good, unmapped spare. With no spare left, `err_short_o` is raised and that address selects nothing.
- R9: A new configuration request clears the previous flags, mapping and errors before the new sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_i | input | 1 | Pulse: start discovery and programming |
| run_i | input | 1 | Operation phase enable |
| wire_code_i | input | NW*CL | Fixed bootstrap code of each wire, wire 0 in the low bits |
| defect_i | input | NW | One per wire: wire is broken |
| addr_valid_i | input | 1 | Logical address is valid |
| addr_i | input | AB | Logical address |
| retire_i | input | 1 | Pulse: retire the wire named by `retire_wire_i` |
| retire_wire_i | input | $clog2(NW) | Index of the wire to retire |
| wire_sel_o | output | NW | Registered one-hot wire select |
| sel_valid_o | output | 1 | Registered select is from a valid address |
| good_o | output | NW | Present-and-good flags |
| cfg_done_o | output | 1 | Mapping complete |
| err_dup_o | output | 1 | Duplicate bootstrap code seen |
| err_short_o | output | 1 | Not every logical address has a wire |

## Verification
The hardest state to reach is a migrated mapping that runs out of spares. Getting there needs a configured array with exactly two spares and three retirements in a row. The stimulus retires two mapped wires, checks after each one that the moved address lands on the next spare and that untouched addresses keep their wires, and then retires a third with no spare left to expose the short error and the dead address. Duplicate codes and a short array are each set up by reconfiguring with altered code and defect vectors, which also shows that old state is cleared.

// File: rtl/defect_map_decoder.sv
module defect_map_decoder #(
  parameter int NW = 8,
  parameter int AB = 2,
  parameter int CL = 5,
  parameter int CW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_start_i,
  input  logic                  run_i,
  input  logic [NW*CL-1:0]      wire_code_i,
  input  logic [NW-1:0]         defect_i,
  input  logic                  addr_valid_i,
  input  logic [AB-1:0]         addr_i,
  input  logic                  retire_i,
  input  logic [$clog2(NW)-1:0] retire_wire_i,
  output logic [NW-1:0]         wire_sel_o,
  output logic                  sel_valid_o,
  output logic [NW-1:0]         good_o,
  output logic                  cfg_done_o,
  output logic                  err_dup_o,
  output logic                  err_short_o
);
  localparam int NA  = 1 << AB;
  localparam int ML  = 2 * AB;
  localparam int WIW = $clog2(NW);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_PROG, S_DONE} state_t;

  state_t           state_q;
  logic [CL-1:0]    scan_v;
  logic [WIW-1:0]   prog_w;
  logic [AB:0]      nxt_q;
  logic [ML-1:0]    mask_q [NW];
  logic [NW-1:0]    mapped_q;
  logic [NW-1:0]    good_q;
  logic [CL-1:0]    code [NW];
  logic [NW-1:0]    hit;
  logic [NW-1:0]    match;
  logic [ML-1:0]    lines;
  logic             take;
  logic [WIW-1:0]   spare_idx;
  logic             spare_ok;

  function automatic logic [ML-1:0] enc(input logic [AB-1:0] a);
    logic [ML-1:0] m;
    for (int b = 0; b < AB; b++) begin
      m[2*b+1] = a[b];
      m[2*b]   = ~a[b];
    end
    return m;
  endfunction

  for (genvar b = 0; b < AB; b++) begin : g_rail
    assign lines[2*b+1] = addr_i[b];
    assign lines[2*b]   = ~addr_i[b];
  end

  for (genvar w = 0; w < NW; w++) begin : g_wire
    assign code[w]  = wire_code_i[w*CL +: CL];
    assign hit[w]   = ($countones(scan_v) == CW) && (code[w] == scan_v) && !defect_i[w];
    assign match[w] = &(~mask_q[w] | lines);
  end

  assign take = good_q[prog_w] && (nxt_q < (AB+1)'(NA));

  always_comb begin
    spare_ok  = 1'b0;
    spare_idx = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (good_q[i] && !mapped_q[i]) begin
        spare_ok  = 1'b1;
        spare_idx = WIW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      scan_v      <= '0;
      prog_w      <= '0;
      nxt_q       <= '0;
      mapped_q    <= '0;
      good_q      <= '0;
      cfg_done_o  <= 1'b0;
      err_dup_o   <= 1'b0;
      err_short_o <= 1'b0;
      for (int w = 0; w < NW; w++) mask_q[w] <= '1;
    end else if (cfg_start_i) begin
      state_q     <= S_SCAN;
      scan_v      <= '0;
      prog_w      <= '0;
      nxt_q       <= '0;
      mapped_q    <= '0;
      good_q      <= '0;
      cfg_done_o  <= 1'b0;
      err_dup_o   <= 1'b0;
      err_short_o <= 1'b0;
      for (int w = 0; w < NW; w++) mask_q[w] <= '1;
    end else begin
      case (state_q)
        S_SCAN: begin
          if ($countones(hit) == 1) good_q <= good_q | hit;
          if ($countones(hit) > 1)  err_dup_o <= 1'b1;
          scan_v <= scan_v + 1'b1;
          if (&scan_v) state_q <= S_PROG;
        end
        S_PROG: begin
          if (take) begin
            mask_q[prog_w]   <= enc(nxt_q[AB-1:0]);
            mapped_q[prog_w] <= 1'b1;
            nxt_q            <= nxt_q + 1'b1;
          end
          prog_w <= prog_w + 1'b1;
          if (prog_w == WIW'(NW - 1)) begin
            state_q     <= S_DONE;
            cfg_done_o  <= 1'b1;
            err_short_o <= (nxt_q + (AB+1)'(take)) < (AB+1)'(NA);
          end
        end
        S_DONE: begin
          if (retire_i) begin
            mask_q[retire_wire_i]   <= '1;
            good_q[retire_wire_i]   <= 1'b0;
            mapped_q[retire_wire_i] <= 1'b0;
            if (mapped_q[retire_wire_i]) begin
              if (spare_ok) begin
                mask_q[spare_idx]   <= mask_q[retire_wire_i];
                mapped_q[spare_idx] <= 1'b1;
              end else begin
                err_short_o <= 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign good_o = good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wire_sel_o  <= '0;
      sel_valid_o <= 1'b0;
    end else begin
      sel_valid_o <= run_i && addr_valid_i && cfg_done_o;
      wire_sel_o  <= (run_i && addr_valid_i && cfg_done_o) ? match : '0;
    end
  end

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wire_sel_o));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_i && addr_valid_i && cfg_done_o) |=> (wire_sel_o == '0) && !sel_valid_o);

  p_short_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_short_o |-> cfg_done_o);

  p_done_after_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done_o) |-> $past(state_q == S_PROG));

  p_sel_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wire_sel_o) |-> sel_valid_o);

  for (genvar w = 0; w < NW; w++) begin : g_chk
    p_parked_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q[w]) |=> !wire_sel_o[w]);
  end
endmodule

// File: tb/sim_defect_map_decoder.sv
`timescale 1ns/1ps
module sim_defect_map_decoder;
  localparam int NW = 8, AB = 2, CL = 5;
  localparam logic [NW*CL-1:0] CODES_A =
    {5'b10100, 5'b11000, 5'b01100, 5'b10001, 5'b01010, 5'b00000, 5'b00101, 5'b00011};
  localparam logic [NW*CL-1:0] CODES_B =
    {5'b10100, 5'b11000, 5'b01100, 5'b10001, 5'b00011, 5'b00000, 5'b00101, 5'b00011};
  localparam logic [AB+NW-1:0] VEC [6] = '{
    {2'd0, 8'h01}, {2'd1, 8'h08}, {2'd2, 8'h10},
    {2'd3, 8'h20}, {2'd1, 8'h08}, {2'd0, 8'h01}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_start_i = 1'b0, run_i = 1'b0, addr_valid_i = 1'b0, retire_i = 1'b0;
  logic [NW*CL-1:0] wire_code_i = CODES_A;
  logic [NW-1:0] defect_i = 8'h02;
  logic [AB-1:0] addr_i = '0;
  logic [2:0] retire_wire_i = '0;
  logic [NW-1:0] wire_sel_o, good_o;
  logic sel_valid_o, cfg_done_o, err_dup_o, err_short_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  defect_map_decoder u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic configure();
    @(negedge clk) cfg_start_i = 1'b1;
    @(negedge clk) cfg_start_i = 1'b0;
    for (int i = 0; i < 200 && !cfg_done_o; i++) @(negedge clk);
  endtask

  task automatic op(input logic [AB-1:0] a, input logic [NW-1:0] exp, input string tag);
    run_i = 1'b1; addr_valid_i = 1'b1; addr_i = a;
    @(negedge clk);
    chk(tag, wire_sel_o, exp);
    addr_valid_i = 1'b0;
  endtask

  task automatic retire(input logic [2:0] w);
    retire_i = 1'b1; retire_wire_i = w;
    @(negedge clk) retire_i = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sel", wire_sel_o, 0);
    chk("R1 flags", {good_o, sel_valid_o, cfg_done_o, err_dup_o, err_short_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk) cfg_start_i = 1'b1;
    @(negedge clk) cfg_start_i = 1'b0;
    op(2'd0, 8'h00, "R7 during config");
    for (int i = 0; i < 200 && !cfg_done_o; i++) @(negedge clk);
    chk("R2 good A", good_o, 8'hF9);
    chk("R3 no dup A", err_dup_o, 0);
    chk("R6 no short A", err_short_o, 0);
    for (int i = 0; i < 6; i++) begin
      op(VEC[i][AB+NW-1:NW], VEC[i][NW-1:0], "R4 vector");
      chk("R4 valid", sel_valid_o, 1);
    end
    run_i = 1'b0; addr_valid_i = 1'b1; addr_i = 2'd2;
    @(negedge clk);
    chk("R7 run low", {wire_sel_o, sel_valid_o}, 0);
    run_i = 1'b1; addr_valid_i = 1'b0;
    @(negedge clk);
    chk("R7 valid low", {wire_sel_o, sel_valid_o}, 0);
    retire(3'd3);
    op(2'd1, 8'h40, "R8 move to w6");
    op(2'd0, 8'h01, "R8 others kept");
    retire(3'd4);
    op(2'd2, 8'h80, "R8 move to w7");
    chk("R8 good after", good_o, 8'hE1);
    chk("R8 short before", err_short_o, 0);
    retire(3'd0);
    chk("R8 no spare short", err_short_o, 1);
    op(2'd0, 8'h00, "R5 retired dark");
    op(2'd3, 8'h20, "R8 addr3 kept");
    wire_code_i = CODES_B; defect_i = 8'h00;
    configure();
    chk("R3 dup", err_dup_o, 1);
    chk("R3 good B", good_o, 8'hF2);
    chk("R9 short cleared", err_short_o, 0);
    op(2'd0, 8'h02, "R3 addr0 B");
    op(2'd1, 8'h10, "R3 addr1 B");
    op(2'd3, 8'h40, "R5 spare w7 dark");
    wire_code_i = CODES_A; defect_i = 8'hF2;
    configure();
    chk("R6 short", err_short_o, 1);
    chk("R9 dup cleared", err_dup_o, 0);
    chk("R6 good C", good_o, 8'h09);
    op(2'd1, 8'h08, "R6 addr1 C");
    op(2'd2, 8'h00, "R6 addr2 none");
    op(2'd3, 8'h00, "R6 addr3 none");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule